// File: doc/BRIEF.md
# Dual-Path Gate Drive Controller

This block is the digital core of an isolated gate driver that has two output paths onto the same power-device gate. The main path copies the drive command after a settable turn-on or turn-off delay. The boost path adds drive strength when it is enabled: it either copies the same command or is released to high impedance. An active-low slew-select pin picks between these two boost modes. A new boost mode is adopted only on a switching edge of the main path, so a gate transition never changes drive strength halfway through.

Three status flags come from analog comparators elsewhere: primary-supply undervoltage, secondary-supply undervoltage and over-temperature. The block turns them into fixed safe pin states. Command pulses shorter than a minimum width are discarded. After a fault, the outputs stay low until the command makes a fresh edge. All inputs are synchronous to `clk`. The outputs are plain level and enable pins. No data stream passes through the block, so it has no handshake and no back-pressure.

Top module: `gate_drive_ctrl`

## Requirements
- R1: During and after reset, `main_oe`=1, `gate_main`=0 and `boost_oe`=0. The boost mode resets to high impedance.
- R2: With no fault, a command level sampled at clock edge k appears on `gate_main` at edge k+PW_MIN+RISE_DLY-1 for a rise and at edge k+PW_MIN+FALL_DLY-1 for a fall. The slew-select level does not change this timing.
- R3: A command pulse held for fewer than PW_MIN consecutive clock edges changes neither output. A pulse held for exactly PW_MIN edges passes.
- R4: In follow mode (`slew_sel_n`=0 adopted), `boost_oe`=1 and `gate_boost` equals `gate_main`. In high-impedance mode (`slew_sel_n`=1 adopted), `boost_oe`=0.
- R5: A change of `slew_sel_n` alters `boost_oe` only in the same cycle as a `gate_main` edge, never before.
- R6: A select level is adopted at an output edge only if it was first sampled at least SETUP_CYC edges before the first edge that samples the new command level. A later change stays pending and is applied at the following output edge.
- R7: While `pri_uv`=1 and `sec_uv`=0, in the same cycle: `main_oe`=1, `gate_main`=0, `boost_oe`=0.
- R8: While `sec_uv`=1, `main_oe`=0 and `boost_oe`=0 in the same cycle, whatever the other inputs are.
- R9: While `ot_trip`=1, `gate_main`=0 and `gate_boost`=0 in the same cycle. The output enables keep their mode values.
- R10: After every fault flag has cleared, `gate_main` stays 0 even if the command is already high. Normal following resumes from the next accepted command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_in | input | 1 | Gate drive command |
| slew_sel_n | input | 1 | Boost mode select, 0 = follow, 1 = high impedance |
| pri_uv | input | 1 | Primary (input-side) supply undervoltage flag |
| sec_uv | input | 1 | Secondary (output-side) supply undervoltage flag |
| ot_trip | input | 1 | Over-temperature flag |
| gate_main | output | 1 | Main path drive level |
| main_oe | output | 1 | Main path output enable, 0 = high impedance |
| gate_boost | output | 1 | Boost path drive level |
| boost_oe | output | 1 | Boost path output enable, 0 = high impedance |

## Verification
The fault flags reach the pins through logic alone, so the result of a flag is due in the same cycle the flag is driven. The command path has a fixed latency: PW_MIN+RISE_DLY cycles after the driving cycle for a rise and PW_MIN+FALL_DLY cycles for a fall. A boost-mode change lands in exactly that same cycle. The bench schedules each expected pin state for the cycle given by these counts, and also for the cycle just before, so that an output arriving one cycle early or late is caught. Select-setup cases sit exactly on SETUP_CYC and one cycle short of it.

// File: rtl/gate_drive_pkg.sv
package gate_drive_pkg;
  typedef enum logic {
    BOOST_HIZ    = 1'b0,
    BOOST_FOLLOW = 1'b1
  } boost_mode_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/gate_drive_filter.sv
module gate_drive_filter #(
  parameter int PW_MIN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic din,
  output logic lvl,
  output logic lvl_edge,
  output logic cand
);
  localparam int CW = $clog2(PW_MIN + 1);

  logic [CW-1:0] cnt;

  // first edge that sees a new command level
  assign cand = !hold && (din != lvl) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl      <= 1'b0;
      cnt      <= '0;
      lvl_edge <= 1'b0;
    end else if (hold) begin
      lvl      <= din;
      cnt      <= '0;
      lvl_edge <= 1'b0;
    end else begin
      lvl_edge <= 1'b0;
      if (din == lvl) begin
        cnt <= '0;
      end else if (cnt == CW'(PW_MIN - 1)) begin
        lvl      <= din;
        cnt      <= '0;
        lvl_edge <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gate_drive_delay.sv
module gate_drive_delay
  import gate_drive_pkg::*;
#(
  parameter int RISE_DLY = 4,
  parameter int FALL_DLY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic lvl,
  input  logic lvl_edge,
  output logic dly,
  output logic fire
);
  localparam int DW = $clog2(max_of(RISE_DLY, FALL_DLY) + 1);

  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;
  logic          armed;
  logic          run;

  assign lim  = lvl ? DW'(RISE_DLY) : DW'(FALL_DLY);
  assign run  = (armed || lvl_edge) && (lvl != dly);
  assign fire = !clear && run && (cnt == lim - DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      dly   <= 1'b0;
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= armed | lvl_edge;
      if (fire) begin
        dly <= lvl;
        cnt <= '0;
      end else if (run) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/gate_drive_slew.sv
module gate_drive_slew
  import gate_drive_pkg::*;
#(
  parameter int SETUP_CYC = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        cand,
  input  logic        out_edge,
  output boost_mode_e mode
);
  localparam int AW = $clog2(SETUP_CYC + 1);

  logic          sel_q;
  logic [AW-1:0] age;
  logic          settled;
  boost_mode_e   pend;

  assign settled = (sel_n == sel_q) && (age >= AW'(SETUP_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
      age   <= AW'(SETUP_CYC - 1);
      pend  <= BOOST_HIZ;
      mode  <= BOOST_HIZ;
    end else begin
      sel_q <= sel_n;
      if (sel_n != sel_q)
        age <= '0;
      else if (age < AW'(SETUP_CYC - 1))
        age <= age + 1'b1;
      if (cand && settled)
        pend <= sel_n ? BOOST_HIZ : BOOST_FOLLOW;
      if (out_edge)
        mode <= pend;
    end
  end
endmodule

// File: rtl/gate_drive_ctrl.sv
module gate_drive_ctrl
  import gate_drive_pkg::*;
#(
  parameter int PW_MIN    = 10,
  parameter int RISE_DLY  = 4,
  parameter int FALL_DLY  = 6,
  parameter int SETUP_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_in,
  input  logic slew_sel_n,
  input  logic pri_uv,
  input  logic sec_uv,
  input  logic ot_trip,
  output logic gate_main,
  output logic main_oe,
  output logic gate_boost,
  output logic boost_oe
);
  logic        fault;
  logic        lvl;
  logic        lvl_edge;
  logic        cand;
  logic        dly;
  logic        fire;
  boost_mode_e mode;

  assign fault = pri_uv | sec_uv | ot_trip;

  gate_drive_filter #(.PW_MIN(PW_MIN)) u_filt (
    .clk(clk), .rst_n(rst_n), .hold(fault), .din(drv_in),
    .lvl(lvl), .lvl_edge(lvl_edge), .cand(cand)
  );

  gate_drive_delay #(.RISE_DLY(RISE_DLY), .FALL_DLY(FALL_DLY)) u_dly (
    .clk(clk), .rst_n(rst_n), .clear(fault), .lvl(lvl),
    .lvl_edge(lvl_edge), .dly(dly), .fire(fire)
  );

  gate_drive_slew #(.SETUP_CYC(SETUP_CYC)) u_slew (
    .clk(clk), .rst_n(rst_n), .sel_n(slew_sel_n), .cand(cand),
    .out_edge(fire), .mode(mode)
  );

  // fault flags act on the pins without a register stage
  always_comb begin
    main_oe    = !sec_uv;
    gate_main  = dly & !fault;
    boost_oe   = !sec_uv && !pri_uv && (mode == BOOST_FOLLOW);
    gate_boost = dly & !fault;
  end
endmodule

// File: rtl/gate_drive_ctrl_chk.sv
module gate_drive_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pri_uv,
  input logic sec_uv,
  input logic ot_trip,
  input logic gate_main,
  input logic main_oe,
  input logic gate_boost,
  input logic boost_oe
);
  logic any_fault;
  assign any_fault = pri_uv | sec_uv | ot_trip;

  AST_SEC_UV_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    sec_uv |-> (!main_oe && !boost_oe)); // R8

  AST_PRI_UV_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_uv && !sec_uv) |-> (main_oe && !gate_main && !boost_oe)); // R7

  AST_OT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ot_trip |-> (!gate_main && !gate_boost)); // R9

  AST_FOLLOW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    boost_oe |-> (gate_boost == gate_main)); // R4

  AST_MODE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_fault && !$past(any_fault) && (boost_oe != $past(boost_oe)))
      |-> (gate_main != $past(gate_main))); // R5

  AST_NO_JUMP_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_fault && $past(any_fault)) |-> !gate_main); // R10
endmodule

bind gate_drive_ctrl gate_drive_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pri_uv(pri_uv), .sec_uv(sec_uv),
  .ot_trip(ot_trip), .gate_main(gate_main), .main_oe(main_oe),
  .gate_boost(gate_boost), .boost_oe(boost_oe)
);

// File: tb/sim_gate_drive_ctrl.sv
`timescale 1ns/1ps
module sim_gate_drive_ctrl;
  localparam int PW    = 10;
  localparam int RISE  = 4;
  localparam int FALL  = 6;
  localparam int SETUP = 20;
  localparam int LR    = PW + RISE;
  localparam int LF    = PW + FALL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv_in = 1'b0;
  logic slew_sel_n = 1'b1;
  logic pri_uv = 1'b0;
  logic sec_uv = 1'b0;
  logic ot_trip = 1'b0;
  logic gate_main, main_oe, gate_boost, boost_oe;

  always #2.5 clk = ~clk;

  gate_drive_ctrl #(.PW_MIN(PW), .RISE_DLY(RISE), .FALL_DLY(FALL), .SETUP_CYC(SETUP)) u0 (
    .clk(clk), .rst_n(rst_n), .drv_in(drv_in), .slew_sel_n(slew_sel_n),
    .pri_uv(pri_uv), .sec_uv(sec_uv), .ot_trip(ot_trip),
    .gate_main(gate_main), .main_oe(main_oe),
    .gate_boost(gate_boost), .boost_oe(boost_oe)
  );

  typedef struct {
    int    cyc;
    bit    mo;
    bit    m;
    bit    bo;
    bit    b;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  // driver side of the scoreboard: schedule an expected pin state
  task automatic expect_at(input int c, input bit mo, input bit m,
                           input bit bo, input bit b, input string tag);
    exp_t e;
    e.cyc = c; e.mo = mo; e.m = m; e.bo = bo; e.b = b; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares scheduled expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      bit ok;
      e = q.pop_front();
      checks++;
      ok = (e.cyc == cyc) && (main_oe == e.mo) && (boost_oe == e.bo) &&
           (!e.mo || gate_main == e.m) && (!e.bo || gate_boost == e.b);
      if (!ok) begin
        fails++;
        $display("FAIL %s cyc %0d (due %0d): actual oe/main/oe/boost=%b%b%b%b expected=%b%b%b%b",
                 e.tag, cyc, e.cyc, main_oe, gate_main, boost_oe, gate_boost,
                 e.mo, e.m, e.bo, e.b);
      end
    end
  end

  initial begin
    int n;
    int m;
    tick(4);
    rst_n = 1'b1;
    expect_at(cyc, 1, 0, 0, 0, "R1");

    // R2: rise and fall timing in high-impedance boost mode
    tick(3); n = cyc; drv_in = 1'b1;
    expect_at(n + LR - 1, 1, 0, 0, 0, "R2");
    expect_at(n + LR,     1, 1, 0, 0, "R2");
    tick(30); n = cyc; drv_in = 1'b0;
    expect_at(n + LF - 1, 1, 1, 0, 0, "R2");
    expect_at(n + LF,     1, 0, 0, 0, "R2");

    // R3: pulse one cycle short of the minimum is dropped
    tick(30); n = cyc; drv_in = 1'b1;
    expect_at(n + LR,      1, 0, 0, 0, "R3");
    expect_at(n + LR + 10, 1, 0, 0, 0, "R3");
    tick(PW - 1); drv_in = 1'b0;
    // R3: pulse of exactly the minimum passes
    tick(30); n = cyc; drv_in = 1'b1;
    expect_at(n + LR, 1, 1, 0, 0, "R3");
    tick(PW); drv_in = 1'b0;
    expect_at(n + PW + LF - 1, 1, 1, 0, 0, "R3");
    expect_at(n + PW + LF,     1, 0, 0, 0, "R3");

    // R5/R6: select to follow exactly SETUP cycles ahead is adopted at the edge
    tick(30); n = cyc; slew_sel_n = 1'b0;
    expect_at(n + 5, 1, 0, 0, 0, "R5");
    tick(SETUP); m = cyc; drv_in = 1'b1;
    expect_at(m + LR - 1, 1, 0, 0, 0, "R5");
    expect_at(m + LR,     1, 1, 1, 1, "R4");
    tick(30); m = cyc; drv_in = 1'b0;
    expect_at(m + LF, 1, 0, 1, 0, "R4");

    // R6: select back to high-Z one cycle too late stays pending
    tick(30); n = cyc; slew_sel_n = 1'b1;
    tick(SETUP - 1); m = cyc; drv_in = 1'b1;
    expect_at(m + LR, 1, 1, 1, 1, "R6");
    tick(30); m = cyc; drv_in = 1'b0;
    expect_at(m + LF - 1, 1, 1, 1, 1, "R6");
    expect_at(m + LF,     1, 0, 0, 0, "R6");

    // back to follow mode, output high
    tick(30); slew_sel_n = 1'b0;
    tick(25); m = cyc; drv_in = 1'b1;
    expect_at(m + LR, 1, 1, 1, 1, "R2");
    tick(LR + 6);

    // R9: over-temperature forces both levels low at once
    ot_trip = 1'b1;
    expect_at(cyc, 1, 0, 1, 0, "R9");
    tick(5); ot_trip = 1'b0;
    // R10: command still high, output must not jump back
    expect_at(cyc,      1, 0, 1, 0, "R10");
    expect_at(cyc + 25, 1, 0, 1, 0, "R10");
    tick(30); drv_in = 1'b0;
    tick(30); m = cyc; drv_in = 1'b1;
    expect_at(m + LR - 1, 1, 0, 1, 0, "R10");
    expect_at(m + LR,     1, 1, 1, 1, "R10");
    tick(LR + 6);

    // R7: primary undervoltage
    pri_uv = 1'b1;
    expect_at(cyc, 1, 0, 0, 0, "R7");
    tick(5); pri_uv = 1'b0;
    expect_at(cyc + 20, 1, 0, 1, 0, "R10");
    tick(25);

    // R8: secondary undervoltage, alone and together with primary
    sec_uv = 1'b1;
    expect_at(cyc, 0, 0, 0, 0, "R8");
    tick(3); pri_uv = 1'b1;
    expect_at(cyc, 0, 0, 0, 0, "R8");
    tick(3); pri_uv = 1'b0; sec_uv = 1'b0;
    expect_at(cyc, 1, 0, 1, 0, "R10");
    tick(40);

    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule